// File: doc/BRIEF.md
# Bus Write FIFO Status Sequencer

This block produces three timed status flags that report the progress of writes moving through a bus write FIFO. Each pulse on a single write strobe starts a staggered sequence. The entry flag rises in the next cycle. A middle flag rises a fixed delay later. An exit flag rises later still. Each flag stays high for its own hold time. The flags overlap, so software that polls the status word sees a write "move" from entry to exit.

A further write that arrives while a sequence is running does not restart it. A flag that is already scheduled to fall has its fall pushed out by its full hold time. A rise that is still pending stays where it was. All deadlines are absolute timestamps, compared against a free-running tick counter inside the block. The status word is read through a plain read-request port. Only the three flag positions can be non-zero.

Top module: `wfs_status_seq`

## Requirements
- R1: A write strobe in cycle t sets status bit 5, seen from a read in cycle t+1. The bit reads low again from cycle t+60.
- R2: After a write in cycle t with no sequence running, status bit 4 reads high in cycles t+60 through t+219. It reads low before and after that window.
- R3: After a write in cycle t with no sequence running, status bit 0 reads high in cycles t+120 through t+539. It reads low before and after that window.
- R4: A write that arrives while a flag's fall is pending moves that fall later by the flag's full hold time: 60 for bit 5, 160 for bit 4, 420 for bit 0.
- R5: A write that arrives while a flag's rise is pending leaves the cycle of that rise unchanged.
- R6: While reset is asserted and right after it is released, every deadline is inactive and a read returns zero.
- R7: A deadline is applied in the cycle it falls due, and a read in that cycle already shows the result. If a write lands in the same cycle as a due deadline, the deadline is handled first, and the write then finds that flag idle and starts it afresh. If a rise and a fall of one flag fall due together, the fall wins.
- R8: With read request high, the read data carries the flags at bits 5, 4 and 0 and zero in every other bit. With read request low, the read data is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One pulse per bus write entering the FIFO |
| rd_req | input | 1 | Status read request |
| rd_data | output | 32 | Status word, valid in the cycle of the request |

## Verification
A deadline falling due and a new write strobe can occur in the same cycle. The most telling case is a second write exactly 60 cycles after the first. In that cycle the entry flag's fall and the middle flag's rise both fall due. The write must then see both as idle: the entry flag restarts from the new write, and the middle flag is given a fresh rise at the new write plus 60. This is provoked on purpose with exact spacing, and also by chance in a long random stretch of writes. A behavioural model with integer deadlines applies the due deadlines before the write in every cycle, and its result is compared with the read data every clock.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

  localparam int unsigned TICK_W = 32;

  typedef logic [TICK_W-1:0] tick_t;

  // Value of a deadline that is not armed.
  localparam tick_t TICK_IDLE = '1;

  // Wrap-safe "deadline reached": the distance from deadline to now,
  // taken as a signed number, is not negative.
  function automatic logic tick_reached(input tick_t now, input tick_t dl);
    tick_t diff;
    diff = now - dl;
    return (dl != TICK_IDLE) && !diff[TICK_W-1];
  endfunction

  // Deadline offset by a number of ticks (modulo the counter width).
  function automatic tick_t tick_after(input tick_t base, input int unsigned n);
    return base + tick_t'(n);
  endfunction

endpackage

// File: rtl/wfs_tick_ctr.sv
module wfs_tick_ctr
  import wfs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output tick_t now
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + tick_t'(1);
  end

endmodule

// File: rtl/wfs_flag_chan.sv
// One status flag with an optional delayed rise and an extendable fall.
// RISE_DLY == 0 selects the variant that rises in the cycle after a write.
module wfs_flag_chan
  import wfs_pkg::*;
#(
  parameter int unsigned RISE_DLY = 60,
  parameter int unsigned HOLD     = 160
) (
  input  logic  clk,
  input  logic  rst_n,
  input  tick_t now,
  input  logic  wr,
  output logic  flag_view,
  output logic  rise_due,
  output logic  fall_due
);

  tick_t fall_dl;
  logic  flag_q;
  logic  rise_pend;
  tick_t rise_eff;
  logic  fall_pend;
  logic  imm_set;

  generate
    if (RISE_DLY == 0) begin : g_immediate
      assign rise_due  = 1'b0;
      assign rise_pend = 1'b0;
      assign rise_eff  = now;
      assign imm_set   = wr;
    end else begin : g_delayed
      tick_t rise_dl;
      tick_t rise_nxt;

      assign rise_due  = tick_reached(now, rise_dl);
      assign rise_pend = (rise_dl != TICK_IDLE) && !rise_due;
      assign rise_eff  = rise_pend ? rise_dl : tick_after(now, RISE_DLY);
      assign imm_set   = 1'b0;

      always_comb begin
        if (wr && !rise_pend) rise_nxt = tick_after(now, RISE_DLY);
        else if (rise_due)    rise_nxt = TICK_IDLE;
        else                  rise_nxt = rise_dl;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_dl <= TICK_IDLE;
        else        rise_dl <= rise_nxt;
      end
    end
  endgenerate

  assign fall_due  = tick_reached(now, fall_dl);
  assign fall_pend = (fall_dl != TICK_IDLE) && !fall_due;

  // Current-cycle view: rise first, fall wins.
  assign flag_view = (flag_q | rise_due) & ~fall_due;

  tick_t fall_nxt;
  always_comb begin
    if (wr) begin
      if (fall_pend) fall_nxt = tick_after(fall_dl, HOLD);
      else           fall_nxt = tick_after(rise_eff, HOLD);
    end else if (fall_due) begin
      fall_nxt = TICK_IDLE;
    end else begin
      fall_nxt = fall_dl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_dl <= TICK_IDLE;
      flag_q  <= 1'b0;
    end else begin
      fall_dl <= fall_nxt;
      flag_q  <= flag_view | imm_set;
    end
  end

endmodule

// File: rtl/wfs_status_seq.sv
module wfs_status_seq
  import wfs_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ENT_POS  = 5,
  parameter int unsigned ENT_HOLD = 60,
  parameter int unsigned MID_POS  = 4,
  parameter int unsigned MID_DLY  = 60,
  parameter int unsigned MID_HOLD = 160,
  parameter int unsigned EXT_POS  = 0,
  parameter int unsigned EXT_DLY  = 120,
  parameter int unsigned EXT_HOLD = 420
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned NCH = 3;
  localparam int unsigned CH_POS  [NCH] = '{ENT_POS, MID_POS, EXT_POS};
  localparam int unsigned CH_DLY  [NCH] = '{0, MID_DLY, EXT_DLY};
  localparam int unsigned CH_HOLD [NCH] = '{ENT_HOLD, MID_HOLD, EXT_HOLD};

  tick_t          now;
  logic [NCH-1:0] flag_view;
  logic [NCH-1:0] set_evt;
  logic [NCH-1:0] clr_evt;

  wfs_tick_ctr u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .now   (now)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wfs_flag_chan #(
      .RISE_DLY (CH_DLY[i]),
      .HOLD     (CH_HOLD[i])
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .now       (now),
      .wr        (wr_stb),
      .flag_view (flag_view[i]),
      .rise_due  (set_evt[i]),
      .fall_due  (clr_evt[i])
    );
  end

  logic [DATA_W-1:0] word;
  always_comb begin
    word = '0;
    for (int i = 0; i < NCH; i++) word[CH_POS[i]] = flag_view[i];
  end

  assign rd_data = rd_req ? word : '0;

endmodule

// File: rtl/wfs_checker.sv
module wfs_checker #(
  parameter int unsigned DATA_W = 32,
  parameter logic [31:0] MASK   = 32'h31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              rd_req,
  input logic [DATA_W-1:0] rd_data,
  input logic [2:0]        view,
  input logic [2:0]        set_evt,
  input logic [2:0]        clr_evt
);

  a_r1_entry_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> view[0]);

  a_r4_entry_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && view[0]) |=> view[0]);

  a_r1_entry_fall_on_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(view[0]) |-> clr_evt[0]);

  a_r2_mid_rise_on_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(view[1]) |-> set_evt[1]);

  a_r3_exit_rise_on_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(view[2]) |-> set_evt[2]);

  a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |-> (rd_data == '0));

  a_r8_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~DATA_W'(MASK)) == '0);

endmodule

bind wfs_status_seq wfs_checker #(
  .DATA_W (DATA_W),
  .MASK   ((32'd1 << ENT_POS) | (32'd1 << MID_POS) | (32'd1 << EXT_POS))
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_stb  (wr_stb),
  .rd_req  (rd_req),
  .rd_data (rd_data),
  .view    (flag_view),
  .set_evt (set_evt),
  .clr_evt (clr_evt)
);

// File: tb/tb_wfs_status_seq.sv
module tb_wfs_status_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R6 reset";

  wfs_status_seq dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .rd_req  (rd_req),
    .rd_data (rd_data)
  );

  always #4 clk = ~clk;

  // Behavioural reference: integer deadlines, -1 when idle.
  int pos  [3] = '{5, 4, 0};
  int dly  [3] = '{0, 60, 120};
  int hold [3] = '{60, 160, 420};
  string tag [3] = '{"R1", "R2", "R3"};
  int on_t [3] = '{-1, -1, -1};
  int off_t[3] = '{-1, -1, -1};
  bit fl   [3] = '{0, 0, 0};
  int cnt = 0;

  task automatic check_word(input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      if (!rd_req)
        $display("FAIL R8 (%s) cycle %0d: rd_data=%h expected=%h", phase, cnt, got, exp);
      else begin
        string r;
        r = "R8";
        for (int i = 0; i < 3; i++) if (got[pos[i]] !== exp[pos[i]]) r = tag[i];
        $display("FAIL %s (%s) cycle %0d: rd_data=%h expected=%h", r, phase, cnt, got, exp);
      end
    end
  endtask

  // One cycle: drive inputs, compare the current view, advance the model.
  task automatic step(input bit wr, input bit rd);
    logic [31:0] w;
    @(negedge clk);
    wr_stb = wr;
    rd_req = rd;
    #1;
    w = '0;
    for (int i = 0; i < 3; i++) begin
      if (on_t[i] == cnt)  begin fl[i] = 1'b1; on_t[i]  = -1; end
      if (off_t[i] == cnt) begin fl[i] = 1'b0; off_t[i] = -1; end
      w[pos[i]] = fl[i];
    end
    check_word(rd_data, rd ? w : 32'h0);
    if (wr) begin
      for (int i = 0; i < 3; i++) begin
        if (dly[i] == 0) begin
          off_t[i] = (off_t[i] != -1) ? off_t[i] + hold[i] : cnt + hold[i];
          fl[i] = 1'b1;
        end else begin
          if (on_t[i] == -1) on_t[i] = cnt + dly[i];
          off_t[i] = (off_t[i] != -1) ? off_t[i] + hold[i] : on_t[i] + hold[i];
        end
      end
    end
    cnt++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b1);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog (%s): run did not end, expected completion", phase);
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    // R6: reset holds the read data at zero.
    rd_req = 1'b1;
    repeat (3) @(negedge clk);
    check_word(rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    phase = "R6 after release";
    idle(4);

    phase = "R1 R2 R3 single write";
    step(1'b1, 1'b1);
    idle(600);

    phase = "R4 R5 two writes 10 apart";
    step(1'b1, 1'b1);
    idle(9);
    step(1'b1, 1'b1);
    idle(1000);

    phase = "R4 R5 burst of five";
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1);
    idle(1600);

    phase = "R7 write on due cycle";
    step(1'b1, 1'b1);
    idle(59);
    step(1'b1, 1'b1);
    idle(59);
    step(1'b1, 1'b1);
    idle(1200);

    phase = "R7 R8 random";
    lf = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[4:0] == 5'd0, lf[9:7] != 3'd0);
    end
    idle(800);
    finish_run();
  end

endmodule